// File: doc/BRIEF.md
# Lane Test Pattern Generator

This block produces the test and training symbol streams for a single lane of a serial display link. It emits one 10-bit symbol per clock. A small write-only register port selects the mode and holds the mode settings. Four modes are available. The first repeats the alternating D10.2 training symbol. The second is a pseudo-random PRBS7 stream. The third is a user-programmed 80-bit pattern sent as eight symbols. The fourth is a scrambled idle stream for symbol-error measurement, and its scrambler returns to its seed after a programmed number of symbols.

The mode word is one-hot. The block shows which mode is running on a 4-bit ready output that repeats the mode bit. Software must write a zero mode word before it starts a different mode. Each time a mode is entered, its generator starts again from its seed or from symbol zero.

Top module: `dp_lane_pattern_gen`

## Requirements
- R1: After reset, `sym_o` is 0 and `ready_o` is 0. The custom pattern registers hold 0x3E0F83E0 at address 1, 0x0F83E0F8 at address 2 and 0x0000F83E at address 3. The scrambler configuration at address 4 holds count 0xFC with the hold bit clear.
- R2: The mode word at address 0 uses its low 4 bits. Bit 0 selects D10.2, bit 1 selects PRBS7, bit 2 selects the custom pattern, and bit 3 selects error measurement. When exactly one bit is set, `ready_o` equals the word in the cycle after the write edge. When the word is zero or has more than one bit set, `ready_o` is 0 and `sym_o` is 0 from the next edge onward.
- R3: Writing zero to address 0 always clears the mode. A nonzero write to address 0 is ignored while the stored word is nonzero, so the running mode and its output continue unchanged.
- R4: In D10.2 mode, every symbol is 10'h155 (bit 0 = 1, then alternating bits).
- R5: In PRBS7 mode, a 7-bit register r starts at 7'h7F. Each bit step computes nb = r[6]^r[5] and sets r = {r[5:0], nb}. The bit emitted is nb, and symbol bit 0 comes first. The symbol stream repeats every 127 symbols.
- R6: In custom mode, the 80-bit value {addr3[15:0], addr2, addr1} is sent as symbol i = bits [10i+9:10i] for i = 0..7, and then the sequence repeats.
- R7: In error-measure mode, a 16-bit register s starts at 16'hFFFF. Each bit step emits b = s[15] and sets s = {s[14:0],0} ^ (b ? 16'h0039 : 0), with symbol bit 0 first. After every N symbols (N = address 4 bits [15:0], N nonzero) the register returns to 16'hFFFF, so the stream has period N.
- R8: When address 4 bit 16 is set, or N is 0, the error-measure scrambler runs freely and never reseeds.
- R9: The first symbol of a mode appears on `sym_o` at the second rising edge after the write edge that selects it. Leaving a mode and entering it again restarts its sequence from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 mode, 1-3 custom pattern, 4 scrambler config) |
| wr_data | input | 32 | Register write data |
| sym_o | output | 10 | Symbol sent this cycle |
| ready_o | output | 4 | One-hot echo of the running mode, 0 when idle or invalid |

## Verification
A corrupted mode register is visible on `ready_o` in the same cycle. A faulty generator or pattern index shows in the next symbol, because every output symbol comes from exactly one register. Mistakes in the PRBS tap or the scrambler seed change the first symbol after entry. A reseed count that is wrong by one stays hidden until the count expires, which is 252 symbols at the default count. For that reason the period is compared at the boundary for both a short count and the default count.

// File: rtl/dp_lane_pattern_gen.sv
module dp_lane_pattern_gen #(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 3,
  parameter int          SYM_W     = 10,
  parameter int          CNT_W     = 16,
  parameter logic [6:0]  PRBS_SEED = 7'h7F,
  parameter logic [15:0] SCR_SEED  = 16'hFFFF,
  parameter logic [15:0] SCR_TAPS  = 16'h0039,
  parameter logic [CNT_W-1:0] CNT_DEFAULT = 'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SYM_W-1:0]  sym_o,
  output logic [3:0]        ready_o
);
  localparam int NMODE  = 4;
  localparam int CUST_W = 80;
  localparam int NSYM   = CUST_W / SYM_W;
  localparam int IDX_W  = $clog2(NSYM);
  localparam int HI_W   = CUST_W - 2 * DATA_W;
  localparam int M_TRN  = 0;
  localparam int M_PRBS = 1;
  localparam int M_CUST = 2;
  localparam int M_ERR  = 3;
  localparam logic [ADDR_W-1:0] A_MODE = 0;
  localparam logic [ADDR_W-1:0] A_C0   = 1;
  localparam logic [ADDR_W-1:0] A_C1   = 2;
  localparam logic [ADDR_W-1:0] A_C2   = 3;
  localparam logic [ADDR_W-1:0] A_CFG  = 4;
  localparam logic [SYM_W-1:0] D102 = SYM_W'(10'h155);

  logic [NMODE-1:0]  mode_q;
  logic [DATA_W-1:0] cust0_q, cust1_q;
  logic [HI_W-1:0]   cust2_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hold_q;
  logic [6:0]        prbs_q, prbs_nx;
  logic [15:0]       scr_q, scr_nx;
  logic [SYM_W-1:0]  prbs_sym, scr_sym;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  run_q;
  logic [CUST_W-1:0] cust;
  logic              valid;
  logic              reseed;

  wire mode_wr = wr_en && (wr_addr == A_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      cust0_q <= DATA_W'(32'h3E0F83E0);
      cust1_q <= DATA_W'(32'h0F83E0F8);
      cust2_q <= HI_W'(16'hF83E);
      cnt_q   <= CNT_DEFAULT;
      hold_q  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_MODE && (wr_data[NMODE-1:0] == '0 || mode_q == '0))
        mode_q <= wr_data[NMODE-1:0];
      if (wr_addr == A_C0) cust0_q <= wr_data;
      if (wr_addr == A_C1) cust1_q <= wr_data;
      if (wr_addr == A_C2) cust2_q <= wr_data[HI_W-1:0];
      if (wr_addr == A_CFG) begin
        cnt_q  <= wr_data[CNT_W-1:0];
        hold_q <= wr_data[CNT_W];
      end
    end
  end

  assign valid   = (mode_q != '0) && ((mode_q & (mode_q - 1'b1)) == '0);
  assign ready_o = valid ? mode_q : '0;
  assign cust    = {cust2_q, cust1_q, cust0_q};
  assign reseed  = !hold_q && (cnt_q != '0) && (run_q == cnt_q - 1'b1);

  always_comb begin
    prbs_nx = prbs_q;
    for (int i = 0; i < SYM_W; i++) begin
      prbs_sym[i] = prbs_nx[6] ^ prbs_nx[5];
      prbs_nx     = {prbs_nx[5:0], prbs_sym[i]};
    end
  end

  always_comb begin
    scr_nx = scr_q;
    for (int i = 0; i < SYM_W; i++) begin
      scr_sym[i] = scr_nx[15];
      scr_nx     = {scr_nx[14:0], 1'b0} ^ (scr_sym[i] ? SCR_TAPS : 16'h0000);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !valid) begin
      sym_o  <= '0;
      prbs_q <= PRBS_SEED;
      scr_q  <= SCR_SEED;
      idx_q  <= '0;
      run_q  <= '0;
    end else begin
      if (mode_q[M_TRN]) sym_o <= D102;
      if (mode_q[M_PRBS]) begin
        sym_o  <= prbs_sym;
        prbs_q <= prbs_nx;
      end
      if (mode_q[M_CUST]) begin
        sym_o <= cust[idx_q * SYM_W +: SYM_W];
        idx_q <= (idx_q == IDX_W'(NSYM - 1)) ? '0 : idx_q + 1'b1;
      end
      if (mode_q[M_ERR]) begin
        sym_o <= scr_sym;
        if (reseed) begin
          scr_q <= SCR_SEED;
          run_q <= '0;
        end else begin
          scr_q <= scr_nx;
          run_q <= run_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lane_pg_chk.sv
module lane_pg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [9:0]  sym_o,
  input logic [3:0]  ready_o
);
  p_ready_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ready_o));

  p_idle_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o == 4'b0000) |=> (sym_o == 10'h000));

  p_train_sym_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o[0] |=> (sym_o == 10'h155));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0 && wr_data[3:0] == 4'b0000) |=> (ready_o == 4'b0000));

  p_no_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o != 4'b0000 && wr_en && wr_addr == 3'd0 && wr_data[3:0] != 4'b0000)
      |=> $stable(ready_o));
endmodule

bind dp_lane_pattern_gen lane_pg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .sym_o(sym_o), .ready_o(ready_o)
);

// File: tb/dp_lane_pattern_gen_tb.sv
`timescale 1ns/1ps
module dp_lane_pattern_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [9:0]  sym_o;
  logic [3:0]  ready_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [9:0]  cap [0:299];
  logic [6:0]  m_prbs;
  logic [15:0] m_scr;

  dp_lane_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sym_o(sym_o), .ready_o(ready_o)
  );

  always #2.5 clk = ~clk;

  // {mode word, expected ready}
  localparam logic [7:0] VEC [8] = '{
    8'b0001_0001, 8'b0010_0010, 8'b0100_0100, 8'b1000_1000,
    8'b0011_0000, 8'b1111_0000, 8'b0101_0000, 8'b1010_0000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap[i] = sym_o;
    end
  endtask

  task automatic prbs_sym(output logic [9:0] s);
    for (int i = 0; i < 10; i++) begin
      s[i] = m_prbs[6] ^ m_prbs[5];
      m_prbs = {m_prbs[5:0], s[i]};
    end
  endtask

  task automatic scr_sym(output logic [9:0] s);
    for (int i = 0; i < 10; i++) begin
      s[i] = m_scr[15];
      m_scr = {m_scr[14:0], 1'b0} ^ (s[i] ? 16'h0039 : 16'h0000);
    end
  endtask

  task automatic check_custom(input string req, input logic [79:0] pat);
    capture(16);
    for (int i = 0; i < 16; i++) chk(req, cap[i], pat[(i % 8) * 10 +: 10]);
  endtask

  task automatic check_scr(input string req, input int period, input int n);
    logic [9:0] e;
    capture(n);
    m_scr = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      if (period > 0 && i % period == 0) m_scr = 16'hFFFF;
      scr_sym(e);
      chk(req, cap[i], e);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sym after reset", sym_o, 0);
    chk("R1 ready after reset", ready_o, 0);

    // R2 table walk
    for (int v = 0; v < 8; v++) begin
      wr(3'd0, 32'h0);
      wr(3'd0, {28'h0, VEC[v][7:4]});
      chk("R2 ready echo", ready_o, VEC[v][3:0]);
      if (VEC[v][3:0] == 4'b0000) begin
        @(negedge clk);
        chk("R2 idle on invalid word", sym_o, 0);
      end
    end
    wr(3'd0, 32'h0);

    // R4 / R9 D10.2
    wr(3'd0, 32'h1);
    chk("R9 no symbol before second edge", sym_o, 0);
    capture(4);
    for (int i = 0; i < 4; i++) chk("R4 D10.2 symbol", cap[i], 10'h155);

    // R3 switching ignored
    wr(3'd0, 32'h2);
    chk("R3 ready held", ready_o, 4'b0001);
    @(negedge clk);
    chk("R3 output held", sym_o, 10'h155);
    wr(3'd0, 32'h0);
    chk("R3 clear ready", ready_o, 0);
    @(negedge clk);
    chk("R3 clear output", sym_o, 0);

    // R5 PRBS7
    wr(3'd0, 32'h2);
    capture(260);
    m_prbs = 7'h7F;
    for (int i = 0; i < 20; i++) begin
      prbs_sym(e);
      chk("R5 prbs symbol", cap[i], e);
    end
    for (int i = 0; i < 130; i++) chk("R5 prbs period 127", cap[i + 127], cap[i]);
    chk("R5 not shorter period", (cap[0] == cap[1]) ? 1 : 0, 0);

    // R9 restart on re-entry
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h2);
    capture(1);
    m_prbs = 7'h7F;
    prbs_sym(e);
    chk("R9 prbs restart", cap[0], e);
    wr(3'd0, 32'h0);

    // R1 / R6 custom defaults, then programmed
    wr(3'd0, 32'h4);
    check_custom("R6 R1 default custom", 80'hF83E_0F83E0F8_3E0F83E0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h89ABCDEF);
    wr(3'd2, 32'h01234567);
    wr(3'd3, 32'hFFFF5A5A);
    wr(3'd0, 32'h4);
    check_custom("R6 programmed custom", 80'h5A5A_01234567_89ABCDEF);
    wr(3'd0, 32'h0);

    // R1 / R7 default count 0xFC
    wr(3'd0, 32'h8);
    check_scr("R7 R1 default count", 252, 256);
    wr(3'd0, 32'h0);

    // R7 short count
    wr(3'd4, 32'h0000_0005);
    wr(3'd0, 32'h8);
    check_scr("R7 count 5", 5, 17);
    wr(3'd0, 32'h0);

    // R8 hold bit set, and count zero
    wr(3'd4, 32'h0001_0005);
    wr(3'd0, 32'h8);
    check_scr("R8 hold free-run", 0, 12);
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h0000_0000);
    wr(3'd0, 32'h8);
    check_scr("R8 zero count free-run", 0, 12);
    wr(3'd0, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule